// File: doc/BRIEF.md
# Switched Branch Current Model

This block models one power semiconductor branch, a MOS transistor with a reverse diode across it, as a discrete-time current source for a real-time circuit emulator. A scheduler pulses a sample strobe once per emulation step. On that strobe the block latches the voltage across the device and the gate command. In the next cycle it decides which device conducts and advances the branch current by one step of a first-order resistive-inductive recurrence. It then raises a one-cycle completion pulse.

The recurrence is `I_new = A1*V + A2*I_old`. Every quantity is a signed fixed-point number with `FRAC_W` fractional bits. The two coefficients are precomputed for the chosen time step and on-state resistance and inductance, and are given as parameters. When the transistor switches on, a fixed snubber discharge current is added to the first step. When neither device conducts, the branch current drops to zero. The published output current changes only when the scheduler pulses a separate store strobe. This lets all branches of the emulated circuit present their results together.

Top module: `switch_branch_model`

## Requirements
- R1: While and right after reset (rstN low), iOut is 0, eoc is 0, transOn is 0 and diodeOn is 0.
- R2: vDev and gateIn are taken only on a clock edge where sampleStb is 1. Changing them in the following cycle has no effect on the step that strobe started.
- R3: A step's conduction flags take effect one clock after the sampling edge. transOn becomes 1 exactly when the sampled voltage is strictly positive and the sampled gate is 1. diodeOn becomes 1 exactly when transOn is 0 and the sampled voltage is negative. The flags are never both 1 and change only on a step.
- R4: While a device conducts, the new current is floor((A1*V + A2*I_old) / 2^FRAC_W), with all values as two's-complement integers.
- R5: On a step where transOn goes from 0 to 1, SNUB_I is added to the R4 result before saturation.
- R6: On a step where neither device conducts, the current becomes 0.
- R7: The new current saturates to the signed DATA_W-bit range [-2^(DATA_W-1), 2^(DATA_W-1)-1].
- R8: eoc is 1 for exactly one cycle per sample strobe, in the cycle where the new flags and current first hold, two clocks after the strobe cycle.
- R9: iOut takes the present branch current on a clock edge where storeStb is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | Start of an emulation step; latches vDev and gateIn |
| gateIn | input | 1 | Transistor gate command |
| vDev | input | DATA_W | Signed fixed-point voltage across the device |
| storeStb | input | 1 | Publish the branch current to iOut |
| iOut | output | DATA_W | Published signed fixed-point branch current |
| transOn | output | 1 | Transistor conducting |
| diodeOn | output | 1 | Reverse diode conducting |
| eoc | output | 1 | One-cycle end-of-step pulse |

## Verification
The bench builds the block with DATA_W=12, FRAC_W=6, A1=48, A2=40 and SNUB_I=5. The effective gain of 2 drives the settled current past full scale for voltages above about half range, so both saturation limits are reached. A sweep across the whole 12-bit voltage range, with both gate values and repeated steps at each point, covers every conduction case, turn-on and turn-off. Each result is compared with an integer model that uses floor division. A separate long run at constant voltage follows the exponential rise step by step and then checks that the current collapses to zero when the gate is removed.

// File: rtl/switch_branch_pkg.sv
package switch_branch_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch voltage and gate
    logic update;   // advance conduction state and current
    logic store;    // publish current
  } swCtl_t;

endpackage

// File: rtl/switch_branch_ctrl.sv
module switch_branch_ctrl
  import switch_branch_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sampleStb,
  input  logic   storeStb,
  output swCtl_t ctl,
  output logic   eoc
);

  logic calcPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calcPend <= 1'b0;
      eoc      <= 1'b0;
    end else begin
      calcPend <= sampleStb;
      eoc      <= calcPend;
    end
  end

  always_comb begin
    ctl.capture = sampleStb;
    ctl.update  = calcPend;
    ctl.store   = storeStb;
  end

endmodule

// File: rtl/switch_branch_dp.sv
module switch_branch_dp
  import switch_branch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter logic signed [DATA_W-1:0] COEF_A1 = 16'sd64,
  parameter logic signed [DATA_W-1:0] COEF_A2 = 16'sd192,
  parameter logic signed [DATA_W-1:0] SNUB_I  = 16'sd0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  swCtl_t                   ctl,
  input  logic                     gateIn,
  input  logic signed [DATA_W-1:0] vDev,
  output logic signed [DATA_W-1:0] iState,
  output logic signed [DATA_W-1:0] iOut,
  output logic                     transOn,
  output logic                     diodeOn
);

  localparam int ACC_W = 2 * DATA_W + 2;
  localparam logic signed [ACC_W-1:0] MAX_I = ACC_W'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] MIN_I = ACC_W'(-(2 ** (DATA_W - 1)));

  logic signed [DATA_W-1:0] vReg;
  logic                     gReg;
  logic                     vPos, vNeg, transNext, diodeNext, turnOn;
  logic signed [ACC_W-1:0]  prodV, prodI, acc, scaled, withSnub;
  logic signed [DATA_W-1:0] iNext;

  // Conduction decision from latched operands
  always_comb begin
    vNeg      = vReg[DATA_W-1];
    vPos      = !vNeg && (vReg != '0);
    transNext = vPos && gReg;
    diodeNext = !transNext && vNeg;
    turnOn    = transNext && !transOn;
  end

  // Fixed-point RL step with saturation
  always_comb begin
    prodV    = ACC_W'(COEF_A1) * ACC_W'(vReg);
    prodI    = ACC_W'(COEF_A2) * ACC_W'(iState);
    acc      = prodV + prodI;
    scaled   = acc >>> FRAC_W;
    withSnub = scaled + (turnOn ? ACC_W'(SNUB_I) : '0);
    if (!(transNext || diodeNext))
      iNext = '0;
    else if (withSnub > MAX_I)
      iNext = DATA_W'(MAX_I);
    else if (withSnub < MIN_I)
      iNext = DATA_W'(MIN_I);
    else
      iNext = DATA_W'(withSnub);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vReg    <= '0;
      gReg    <= 1'b0;
      iState  <= '0;
      iOut    <= '0;
      transOn <= 1'b0;
      diodeOn <= 1'b0;
    end else begin
      if (ctl.capture) begin
        vReg <= vDev;
        gReg <= gateIn;
      end
      if (ctl.update) begin
        iState  <= iNext;
        transOn <= transNext;
        diodeOn <= diodeNext;
      end
      if (ctl.store) iOut <= iState;
    end
  end

endmodule

// File: rtl/switch_branch_model.sv
module switch_branch_model
  import switch_branch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter logic signed [DATA_W-1:0] COEF_A1 = 16'sd64,
  parameter logic signed [DATA_W-1:0] COEF_A2 = 16'sd192,
  parameter logic signed [DATA_W-1:0] SNUB_I  = 16'sd0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleStb,
  input  logic                     gateIn,
  input  logic signed [DATA_W-1:0] vDev,
  input  logic                     storeStb,
  output logic signed [DATA_W-1:0] iOut,
  output logic                     transOn,
  output logic                     diodeOn,
  output logic                     eoc
);

  swCtl_t                   ctl;
  logic signed [DATA_W-1:0] iState;

  switch_branch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .storeStb(storeStb),
    .ctl(ctl), .eoc(eoc)
  );

  switch_branch_dp #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W),
    .COEF_A1(COEF_A1), .COEF_A2(COEF_A2), .SNUB_I(SNUB_I)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .gateIn(gateIn), .vDev(vDev),
    .iState(iState), .iOut(iOut), .transOn(transOn), .diodeOn(diodeOn)
  );

endmodule

// File: rtl/switch_branch_chk.sv
module switch_branch_chk #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleStb,
  input logic                     storeStb,
  input logic                     transOn,
  input logic                     diodeOn,
  input logic                     eoc,
  input logic signed [DATA_W-1:0] iOut,
  input logic signed [DATA_W-1:0] iState
);

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(transOn && diodeOn));

  p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |-> ##2 ($stable(transOn) && $stable(diodeOn)));

  p_off_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (eoc && !transOn && !diodeOn) |-> (iState == '0));

  p_eoc_after_sample_r8: assert property (@(posedge clk) disable iff (!rstN)
    eoc |-> $past(sampleStb, 2));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !storeStb |=> $stable(iOut));

  p_out_copy_r9: assert property (@(posedge clk) disable iff (!rstN)
    storeStb |=> (iOut == $past(iState)));

endmodule

bind switch_branch_model switch_branch_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/switch_branch_model_tb.sv
module switch_branch_model_tb;

  localparam int DATA_W = 12;
  localparam int FRAC_W = 6;
  localparam int A1 = 48;
  localparam int A2 = 40;
  localparam int SNUB = 5;
  localparam longint MAXI = 2047;
  localparam longint MINI = -2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0;
  logic gateIn = 1'b0;
  logic signed [DATA_W-1:0] vDev = '0;
  logic storeStb = 1'b0;
  logic signed [DATA_W-1:0] iOut;
  logic transOn, diodeOn, eoc;

  int checks = 0;
  int fails = 0;
  longint iRef = 0;
  bit prevTrans = 0;

  always #2.5 clk = ~clk;

  switch_branch_model #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W),
    .COEF_A1(12'sd48), .COEF_A2(12'sd40), .SNUB_I(12'sd5)
  ) u_dut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .gateIn(gateIn),
    .vDev(vDev), .storeStb(storeStb), .iOut(iOut),
    .transOn(transOn), .diodeOn(diodeOn), .eoc(eoc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // One emulation step, then a store; tag names the requirement of the current result
  task automatic doStep(input longint v, input bit g, input string tag);
    bit tr, di;
    longint acc, oldOut;
    tr = (v > 0) && g;
    di = !tr && (v < 0);
    if (tr || di) begin
      acc = (A1 * v + A2 * iRef) >>> FRAC_W;
      if (tr && !prevTrans) acc = acc + SNUB;
      if (acc > MAXI) acc = MAXI;
      if (acc < MINI) acc = MINI;
    end else acc = 0;
    iRef = acc;
    prevTrans = tr;
    oldOut = longint'(iOut);

    @(negedge clk);
    vDev = DATA_W'(v);
    gateIn = g;
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    vDev = ~vDev;            // R2: disturb operands after capture
    gateIn = ~gateIn;
    @(negedge clk);
    chk(eoc == 1'b1, "R8 eoc high", longint'(eoc), 1);
    chk(transOn == tr, "R3 transOn", longint'(transOn), longint'(tr));
    chk(diodeOn == di, "R3 diodeOn", longint'(diodeOn), longint'(di));
    chk(longint'(iOut) == oldOut, "R9 iOut held", longint'(iOut), oldOut);
    @(negedge clk);
    chk(eoc == 1'b0, "R8 eoc single", longint'(eoc), 0);
    storeStb = 1'b1;
    @(negedge clk);
    storeStb = 1'b0;
    chk(longint'(iOut) == iRef, tag, longint'(iOut), iRef);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(iOut == '0, "R1 iOut", longint'(iOut), 0);
    chk(eoc == 1'b0, "R1 eoc", longint'(eoc), 0);
    chk(transOn == 1'b0 && diodeOn == 1'b0, "R1 flags",
        longint'({transOn, diodeOn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(iOut == '0, "R1 iOut after release", longint'(iOut), 0);

    // R2: operands changed right after the strobe must not matter
    doStep(100, 1'b1, "R2 R5 captured operands with turn-on");
    // R4: exponential rise at constant voltage
    for (int k = 0; k < 25; k++) doStep(300, 1'b1, "R4 rise");
    // R6: gate removed, current collapses
    doStep(300, 1'b0, "R6 gate off");
    doStep(0, 1'b1, "R6 zero voltage");
    // R5: turn-on again adds snubber term
    doStep(20, 1'b1, "R5 turn-on");
    // R7: saturation both ways
    for (int k = 0; k < 8; k++) doStep(2047, 1'b1, "R7 upper limit");
    for (int k = 0; k < 8; k++) doStep(-2048, 1'b0, "R7 lower limit");
    // Sweep across the whole voltage range and both gate values
    for (int g = 0; g < 2; g++) begin
      for (int v = -2048; v < 2048; v += 97) begin
        for (int r = 0; r < 3; r++) doStep(longint'(v), g[0], "R4 R6 sweep");
      end
    end
    finishRun();
  end

endmodule